// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Unit

This execution unit handles the second-byte group of an 8-bit CPU's prefixed instructions. Each cycle it takes a sub-opcode, one data operand and the current flags. It returns the new operand value, a write-enable for that value and the updated flags. Reading the operand from a register or memory, and writing the value back, is left to the surrounding datapath. The unit reports which operand the sub-opcode names so that the datapath can route it.

The sub-opcode has three fields. Bits 7..6 give the group: 00 shift/rotate, 01 bit test, 10 bit clear, 11 bit set. Bits 5..3 give either the shift kind or the bit index. Bits 2..0 name the operand. A mode input picks the CPU variant. In compact mode (`full_mode_i`=0) shift kind 110 swaps the two nibbles. In full mode the same kind shifts left and fills bit 0 with 1. A second input marks the accumulator-only unprefixed rotates when they are sent through the same unit. For those, the zero flag is always cleared.

Flags use a 4-bit vector: bit 3 zero (Z), bit 2 subtract (N), bit 1 half-carry (H), bit 0 carry (C). All outputs are registered, so they appear one clock after the inputs.

Top module: `srb_unit`

## Requirements
- R1: Shift kinds 000 (bits 5..3 of a group-00 sub-opcode) rotate left circular and 001 rotate right circular. Carry takes the bit that moved from one end to the other.
- R2: Shift kinds 010 and 011 rotate left and right through carry. Carry-in enters the vacated bit and carry takes the bit shifted out.
- R3: Kind 100 shifts left with bit 0 filled by 0. Kind 101 shifts right and keeps bit 7. Kind 111 shifts right with bit 7 filled by 0. Carry takes the bit shifted out.
- R4: Kind 110 exchanges the nibbles and clears carry when `full_mode_i`=0. When `full_mode_i`=1 it shifts left with bit 0 filled by 1, and carry takes old bit 7.
- R5: Every group-00 operation clears N and H. Z is set exactly when the result is zero, unless R8 applies.
- R6: Bit test (group 01) sets Z when the operand bit selected by bits 5..3 is 0, clears N, sets H and keeps C from `flags_i`. It deasserts `wr_en_o` and returns the operand unchanged.
- R7: Bit clear (group 10) and bit set (group 11) change only the selected bit, assert `wr_en_o` and pass `flags_i` through unchanged.
- R8: With `acc_form_i`=1, a group-00 operation drives Z to 0 whatever the result.
- R9: `reg_sel_o` carries sub-opcode bits 2..0. `mem_operand_o` is high exactly when that field is 110, the memory operand.
- R10: Outputs follow the inputs by one clock. `valid_o` repeats `valid_i`, and `wr_en_o` is never high while `valid_o` is low. After reset `valid_o` and `wr_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 8 | Sub-opcode |
| operand_i | input | 8 | Data operand |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| full_mode_i | input | 1 | 1: kind 110 is shift-left-fill-1; 0: nibble swap |
| acc_form_i | input | 1 | Accumulator-only rotate form, forces Z to 0 |
| valid_o | output | 1 | Outputs hold a result |
| result_o | output | 8 | New operand value |
| wr_en_o | output | 1 | Write the result back |
| flags_o | output | 4 | Updated flags {Z,N,H,C} |
| reg_sel_o | output | 3 | Operand select field |
| mem_operand_o | output | 1 | Operand is the memory location |

## Verification
The assertions run on every cycle and check the flag rules that hold across whole groups:
- N and H are cleared for shifts and rotates.
- Z follows the result, except that it is forced low for the accumulator form.
- Bit test keeps the carry and suppresses the write.
- Bit set and bit clear pass the flags through.
- A write is never requested without a valid result.

Only the bench scenarios show the exact bit movement of each shift kind, the carry-in path, the two meanings of kind 110 under each mode, and which bit a set, clear or test touches.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned FLAG_W = 4;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SK_ROL   = 3'd0,
    SK_ROR   = 3'd1,
    SK_ROLC  = 3'd2,
    SK_RORC  = 3'd3,
    SK_SHL0  = 3'd4,
    SK_SHRA  = 3'd5,
    SK_SWAP  = 3'd6,
    SK_SHR0  = 3'd7
  } shift_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;
endpackage

// File: rtl/srb_shifter.sv
module srb_shifter
  import srb_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  shift_e         kind_i,
  input  logic [W-1:0]   data_i,
  input  logic           carry_i,
  input  logic           full_mode_i,
  output logic [W-1:0]   data_o,
  output logic           carry_o
);
  localparam int unsigned HALF = W / 2;

  always_comb begin
    data_o  = data_i;
    carry_o = 1'b0;
    unique case (kind_i)
      SK_ROL:  begin data_o = {data_i[W-2:0], data_i[W-1]}; carry_o = data_i[W-1]; end
      SK_ROR:  begin data_o = {data_i[0], data_i[W-1:1]};   carry_o = data_i[0];   end
      SK_ROLC: begin data_o = {data_i[W-2:0], carry_i};     carry_o = data_i[W-1]; end
      SK_RORC: begin data_o = {carry_i, data_i[W-1:1]};     carry_o = data_i[0];   end
      SK_SHL0: begin data_o = {data_i[W-2:0], 1'b0};        carry_o = data_i[W-1]; end
      SK_SHRA: begin data_o = {data_i[W-1], data_i[W-1:1]}; carry_o = data_i[0];   end
      SK_SWAP: begin
        if (full_mode_i) begin
          data_o  = {data_i[W-2:0], 1'b1};
          carry_o = data_i[W-1];
        end else begin
          data_o  = {data_i[HALF-1:0], data_i[W-1:HALF]};
          carry_o = 1'b0;
        end
      end
      SK_SHR0: begin data_o = {1'b0, data_i[W-1:1]};        carry_o = data_i[0];   end
      default: begin data_o = data_i; carry_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/srb_bitop.sv
module srb_bitop
  import srb_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  grp_e             grp_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [W-1:0]     data_i,
  output logic [W-1:0]     data_o,
  output logic             bit_zero_o
);
  logic [W-1:0] mask;

  always_comb begin
    mask       = '0;
    mask[idx_i] = 1'b1;
    bit_zero_o = ~data_i[idx_i];
    unique case (grp_i)
      GRP_SET: data_o = data_i | mask;
      GRP_CLR: data_o = data_i & ~mask;
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/srb_unit.sv
module srb_unit
  import srb_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic [DATA_W-1:0]   operand_i,
  input  logic [FLAG_W-1:0]   flags_i,
  input  logic                full_mode_i,
  input  logic                acc_form_i,
  output logic                valid_o,
  output logic [DATA_W-1:0]   result_o,
  output logic                wr_en_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic [SEL_W-1:0]    reg_sel_o,
  output logic                mem_operand_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  grp_e               grp;
  shift_e             kind;
  logic [IDX_W-1:0]   idx;
  flags_t             f_in, f_nxt;
  logic [DATA_W-1:0]  sh_data, bo_data, res_nxt;
  logic               sh_carry, bo_zero;

  assign grp  = grp_e'(op_i[7:6]);
  assign kind = shift_e'(op_i[5:3]);
  assign idx  = op_i[5:3];
  assign f_in = flags_t'(flags_i);

  srb_shifter #(.W(DATA_W)) u_shift (
    .kind_i      (kind),
    .data_i      (operand_i),
    .carry_i     (f_in.c),
    .full_mode_i (full_mode_i),
    .data_o      (sh_data),
    .carry_o     (sh_carry)
  );

  srb_bitop #(.W(DATA_W)) u_bitop (
    .grp_i      (grp),
    .idx_i      (idx),
    .data_i     (operand_i),
    .data_o     (bo_data),
    .bit_zero_o (bo_zero)
  );

  always_comb begin
    f_nxt   = f_in;
    res_nxt = bo_data;
    unique case (grp)
      GRP_SHIFT: begin
        res_nxt = sh_data;
        f_nxt.z = acc_form_i ? 1'b0 : (sh_data == '0);
        f_nxt.n = 1'b0;
        f_nxt.h = 1'b0;
        f_nxt.c = sh_carry;
      end
      GRP_TEST: begin
        f_nxt.z = bo_zero;
        f_nxt.n = 1'b0;
        f_nxt.h = 1'b1;
      end
      default: f_nxt = f_in;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      wr_en_o       <= 1'b0;
      result_o      <= '0;
      flags_o       <= '0;
      reg_sel_o     <= '0;
      mem_operand_o <= 1'b0;
    end else begin
      valid_o       <= valid_i;
      wr_en_o       <= valid_i && (grp != GRP_TEST);
      result_o      <= res_nxt;
      flags_o       <= f_nxt;
      reg_sel_o     <= op_i[2:0];
      mem_operand_o <= (op_i[2:0] == SEL_MEM);
    end
  end

  assert_shift_nh_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i[7:6]) == 2'b00) |-> (flags_o[2:1] == 2'b00));

  assert_shift_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i[7:6]) == 2'b00 && !$past(acc_form_i))
      |-> (flags_o[3] == (result_o == '0)));

  assert_acc_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i[7:6]) == 2'b00 && $past(acc_form_i)) |-> !flags_o[3]);

  assert_test_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i[7:6]) == 2'b01)
      |-> (!wr_en_o && flags_o[0] == $past(flags_i[0]) && flags_o[1]
           && result_o == $past(operand_i)));

  assert_setclr_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i[7])) |-> (flags_o == $past(flags_i) && wr_en_o));

  assert_no_idle_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !wr_en_o);

  assert_mem_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_operand_o |-> (reg_sel_o == SEL_MEM));
endmodule

// File: tb/srb_unit_tb.sv
module srb_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic [3:0] flags_i = '0;
  logic       full_mode_i = 1'b0;
  logic       acc_form_i = 1'b0;
  logic       valid_o, wr_en_o, mem_operand_o;
  logic [7:0] result_o;
  logic [3:0] flags_o;
  logic [2:0] reg_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srb_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .flags_i(flags_i), .full_mode_i(full_mode_i),
    .acc_form_i(acc_form_i), .valid_o(valid_o), .result_o(result_o),
    .wr_en_o(wr_en_o), .flags_o(flags_o), .reg_sel_o(reg_sel_o),
    .mem_operand_o(mem_operand_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply at negedge, outputs registered at next posedge, sample at following negedge
  task automatic run_op(string req, logic [7:0] op, logic [7:0] d, logic [3:0] f,
                        logic fm, logic acc, logic [7:0] exp_res, logic exp_we,
                        logic [3:0] exp_f);
    valid_i = 1'b1; op_i = op; operand_i = d; flags_i = f;
    full_mode_i = fm; acc_form_i = acc;
    @(negedge clk);
    valid_i = 1'b0;
    check({req, " valid"}, 32'(valid_o), 32'd1);
    check({req, " result"}, 32'(result_o), 32'(exp_res));
    check({req, " wr_en"}, 32'(wr_en_o), 32'(exp_we));
    check({req, " flags"}, 32'(flags_o), 32'(exp_f));
  endtask

  task automatic t_reset;
    check("R10 reset valid", 32'(valid_o), 32'd0);
    check("R10 reset wr_en", 32'(wr_en_o), 32'd0);
  endtask

  task automatic t_circular;  // R1
    run_op("R1 rol", 8'h00, 8'h85, 4'b0000, 0, 0, 8'h0B, 1, 4'b0001);
    run_op("R1 ror", 8'h09, 8'h01, 4'b0110, 0, 0, 8'h80, 1, 4'b0001);
    run_op("R1 ror even", 8'h0A, 8'h02, 4'b0001, 0, 0, 8'h01, 1, 4'b0000);
  endtask

  task automatic t_thru_carry;  // R2
    run_op("R2 rolc cin1", 8'h10, 8'h80, 4'b0001, 0, 0, 8'h01, 1, 4'b0001);
    run_op("R2 rorc cin0", 8'h1B, 8'h01, 4'b0000, 0, 0, 8'h00, 1, 4'b1001);
    run_op("R2 rorc cin1", 8'h18, 8'h02, 4'b0001, 0, 0, 8'h81, 1, 4'b0000);
  endtask

  task automatic t_shifts;  // R3
    run_op("R3 shl0", 8'h20, 8'h80, 4'b0000, 0, 0, 8'h00, 1, 4'b1001);
    run_op("R3 shra", 8'h2F, 8'h81, 4'b0000, 0, 0, 8'hC0, 1, 4'b0001);
    run_op("R3 shr0", 8'h38, 8'h81, 4'b0110, 0, 0, 8'h40, 1, 4'b0001);
  endtask

  task automatic t_swap_slot;  // R4
    run_op("R4 swap compact", 8'h30, 8'hF1, 4'b0111, 0, 0, 8'h1F, 1, 4'b0000);
    run_op("R4 swap zero", 8'h37, 8'h00, 4'b0001, 0, 0, 8'h00, 1, 4'b1000);
    run_op("R4 shl1 full", 8'h30, 8'h80, 4'b0000, 1, 0, 8'h01, 1, 4'b0001);
    run_op("R4 shl1 full nc", 8'h31, 8'h41, 4'b0001, 1, 0, 8'h83, 1, 4'b0000);
  endtask

  task automatic t_flags_nh;  // R5
    run_op("R5 nh cleared", 8'h08, 8'h00, 4'b0110, 0, 0, 8'h00, 1, 4'b1000);
  endtask

  task automatic t_bit_test;  // R6
    run_op("R6 test clear bit", 8'h78, 8'h7F, 4'b0001, 0, 0, 8'h7F, 0, 4'b1011);
    run_op("R6 test set bit", 8'h50, 8'h04, 4'b0100, 0, 0, 8'h04, 0, 4'b0010);
  endtask

  task automatic t_set_clr;  // R7
    run_op("R7 set bit3", 8'hD8, 8'h00, 4'b1010, 0, 0, 8'h08, 1, 4'b1010);
    run_op("R7 clr bit0", 8'h87, 8'hFF, 4'b0101, 0, 0, 8'hFE, 1, 4'b0101);
    run_op("R7 clr bit7", 8'hB8, 8'h80, 4'b1111, 0, 0, 8'h00, 1, 4'b1111);
  endtask

  task automatic t_acc_form;  // R8
    run_op("R8 acc rol", 8'h07, 8'h80, 4'b1000, 0, 1, 8'h01, 1, 4'b0001);
    run_op("R8 acc zero result", 8'h17, 8'h80, 4'b0000, 0, 1, 8'h00, 1, 4'b0001);
  endtask

  task automatic t_reg_field;  // R9
    run_op("R9 mem op", 8'h46, 8'h01, 4'b0000, 0, 0, 8'h01, 0, 4'b0010);
    check("R9 sel mem", 32'(reg_sel_o), 32'd6);
    check("R9 mem flag", 32'(mem_operand_o), 32'd1);
    run_op("R9 reg a", 8'hC7, 8'h00, 4'b0000, 0, 0, 8'h01, 1, 4'b0000);
    check("R9 sel a", 32'(reg_sel_o), 32'd7);
    check("R9 not mem", 32'(mem_operand_o), 32'd0);
  endtask

  task automatic t_idle;  // R10
    @(negedge clk);
    check("R10 idle valid", 32'(valid_o), 32'd0);
    check("R10 idle wr_en", 32'(wr_en_o), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_circular();
    t_thru_carry();
    t_shifts();
    t_swap_slot();
    t_flags_nh();
    t_bit_test();
    t_set_clr();
    t_acc_form();
    t_reg_field();
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule